// File: doc/BRIEF.md
# SIMD Array Instruction Broadcaster

This block feeds a square mesh of bit-serial processing elements. An instruction of 20 bits reaches it over a 5-bit port as four transfers in a fixed order: the first read address, the second read address, the operation code, and the write address. The block gathers the four parts. It then decodes each part once, centrally, into a 32-line one-hot group. During a single execute cycle it drives the four groups to every element at the same moment, so no element carries a decoder of its own.

The block also routes the mesh. Each element's single output bit is wired to the element above, below, left and right of it. A neighbour position that falls outside the array reads as zero. Each element also receives its own sensor bit. The array side is a parameter (default 8, with 16 and 64 as intended sizes). Element index is `row*N + col`, and row 0 is the top row.

The sequencer has six states. IDLE is the state after reset. GET_A, GET_B, GET_OP and GET_W each wait for one transfer. EXEC is the one broadcast cycle. The transitions are:
- IDLE holds until start.
- start moves any state to GET_A.
- An accepted transfer advances GET_A→GET_B→GET_OP→GET_W.
- An accepted transfer in GET_W moves to EXEC.
- EXEC always moves to GET_A.

Top module: `simd_bcast_array`

## Requirements
- R1: After reset, `exec_o` is 0, all four select groups are all-zero, and the sequencer is in IDLE.
- R2: The four accepted transfers after GET_A are taken in this order: read address A, read address B, opcode, write address. During EXEC, `sel_a`, `sel_b`, `op_line` and `sel_w` each equal `1 << field` of the matching transfer, where bit k of a group means value k.
- R3: `exec_o` is high for exactly one cycle. It goes high in the cycle that follows the clock edge where the fourth transfer is accepted.
- R4: All four select groups are all-zero whenever `exec_o` is low. Each group has exactly one bit set while `exec_o` is high.
- R5: A start pulse throws away any partly gathered instruction and returns to GET_A. A transfer offered in the same cycle as start is not accepted.
- R6: In IDLE (no start since reset), transfers are ignored and no execute cycle occurs.
- R7: Cycles where `step_valid` is low neither advance nor disturb the gathering, so gaps between transfers are allowed.
- R8: A transfer offered during EXEC is ignored. EXEC moves to GET_A, so the next instruction needs no new start.
- R9: A start during EXEC does not shorten the execute cycle. The following instruction is gathered normally.
- R10: For element (r,c), `nbr_up` takes `pe_out` of (r-1,c), `nbr_down` takes (r+1,c), `nbr_left` takes (r,c-1), and `nbr_right` takes (r,c+1).
- R11: A neighbour position outside the array delivers 0.
- R12: `pe_sensor[i]` equals `sensor_bits[i]` for every element i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restart the instruction gathering |
| step_valid | input | 1 | A transfer is offered this cycle |
| step_data | input | STEP_W | Transfer payload |
| sensor_bits | input | N*N | One sensor bit per element |
| pe_out | input | N*N | Output bit of each element |
| exec_o | output | 1 | Array-wide execute strobe |
| sel_a | output | 2**STEP_W | One-hot read select A |
| sel_b | output | 2**STEP_W | One-hot read select B |
| op_line | output | 2**STEP_W | One-hot operation line |
| sel_w | output | 2**STEP_W | One-hot write select |
| nbr_up | output | N*N | Bit from the element above |
| nbr_down | output | N*N | Bit from the element below |
| nbr_left | output | N*N | Bit from the element to the left |
| nbr_right | output | N*N | Bit from the element to the right |
| pe_sensor | output | N*N | Sensor bit routed to each element |

## Verification
The bench targets the cases where the gathering can slip:
- A restart part-way through an instruction. A design that kept the stale fields would broadcast the wrong first address.
- A transfer coinciding with start. A design that accepted it would shift every field by one slot.
- Transfers offered before any start, or during the execute cycle. Accepting them would either produce a phantom execute or corrupt the next instruction.
- Field values 0 and 31, to expose off-by-one decoding.

For the mesh, single-bit and dense patterns are applied at corners and edges. A swapped direction, or a wrap-around where zero belongs, shows up as a mismatched neighbour vector.

// File: rtl/simd_bc_pkg.sv
package simd_bc_pkg;

    localparam int STEPS  = 4;
    localparam int FLD_A  = 0;
    localparam int FLD_B  = 1;
    localparam int FLD_OP = 2;
    localparam int FLD_W  = 3;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_GET_A  = 3'd1,
        ST_GET_B  = 3'd2,
        ST_GET_OP = 3'd3,
        ST_GET_W  = 3'd4,
        ST_EXEC   = 3'd5
    } seq_state_t;

endpackage

// File: rtl/bc_seq.sv
module bc_seq
    import simd_bc_pkg::*;
#(
    parameter int STEP_W = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic                             step_valid,
    input  logic [STEP_W-1:0]                step_data,
    output logic                             exec_o,
    output logic [STEPS-1:0][STEP_W-1:0]     fields_o
);

    seq_state_t state_q, state_d;
    logic [STEPS-1:0][STEP_W-1:0] fields_q;
    logic take;
    logic [1:0] slot;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_IDLE;
            ST_GET_A:  if (step_valid) state_d = ST_GET_B;
            ST_GET_B:  if (step_valid) state_d = ST_GET_OP;
            ST_GET_OP: if (step_valid) state_d = ST_GET_W;
            ST_GET_W:  if (step_valid) state_d = ST_EXEC;
            ST_EXEC:   state_d = ST_GET_A;
            default:   state_d = ST_IDLE;
        endcase
        if (start) state_d = ST_GET_A;
    end

    // which field slot the current state fills
    always_comb begin
        take = 1'b0;
        slot = 2'd0;
        unique case (state_q)
            ST_GET_A:  begin take = step_valid && !start; slot = 2'(FLD_A);  end
            ST_GET_B:  begin take = step_valid && !start; slot = 2'(FLD_B);  end
            ST_GET_OP: begin take = step_valid && !start; slot = 2'(FLD_OP); end
            ST_GET_W:  begin take = step_valid && !start; slot = 2'(FLD_W);  end
            default:   begin take = 1'b0; slot = 2'd0; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    fields_q <= '0;
        else if (take) fields_q[slot] <= step_data;
    end

    // outputs
    always_comb begin
        exec_o   = (state_q == ST_EXEC);
        fields_o = fields_q;
    end

    AST_EXEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |=> !exec_o); // R3

    AST_EXEC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |-> $past(state_q == ST_GET_W && step_valid && !start)); // R3

    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == ST_GET_A)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE)); // R6

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC) |=> $stable(fields_q)); // R8

endmodule

// File: rtl/onehot_dec.sv
module onehot_dec #(
    parameter int IN_W = 5,
    localparam int OUT_W = 1 << IN_W
) (
    input  logic [IN_W-1:0]  code,
    output logic [OUT_W-1:0] lines
);

    for (genvar k = 0; k < OUT_W; k++) begin : g_line
        assign lines[k] = (code == IN_W'(k));
    end

endmodule

// File: rtl/bc_gate.sv
module bc_gate #(
    parameter int LANES = 4,
    parameter int W     = 32
) (
    input  logic                     en,
    input  logic [LANES-1:0][W-1:0]  din,
    output logic [LANES-1:0][W-1:0]  dout
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g] = en ? din[g] : '0;
    end

endmodule

// File: rtl/mesh_route.sv
module mesh_route #(
    parameter int N = 8,
    localparam int CELLS = N * N
) (
    input  logic [CELLS-1:0] pe_out,
    input  logic [CELLS-1:0] sensor_bits,
    output logic [CELLS-1:0] nbr_up,
    output logic [CELLS-1:0] nbr_down,
    output logic [CELLS-1:0] nbr_left,
    output logic [CELLS-1:0] nbr_right,
    output logic [CELLS-1:0] pe_sensor
);

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            localparam int IDX = r * N + c;

            if (r == 0) begin : g_top
                assign nbr_up[IDX] = 1'b0;
            end else begin : g_up
                assign nbr_up[IDX] = pe_out[IDX - N];
            end

            if (r == N - 1) begin : g_bot
                assign nbr_down[IDX] = 1'b0;
            end else begin : g_dn
                assign nbr_down[IDX] = pe_out[IDX + N];
            end

            if (c == 0) begin : g_lft
                assign nbr_left[IDX] = 1'b0;
            end else begin : g_lf
                assign nbr_left[IDX] = pe_out[IDX - 1];
            end

            if (c == N - 1) begin : g_rgt
                assign nbr_right[IDX] = 1'b0;
            end else begin : g_rt
                assign nbr_right[IDX] = pe_out[IDX + 1];
            end

            assign pe_sensor[IDX] = sensor_bits[IDX];
        end
    end

endmodule

// File: rtl/simd_bcast_array.sv
module simd_bcast_array
    import simd_bc_pkg::*;
#(
    parameter int N      = 8,
    parameter int STEP_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      step_valid,
    input  logic [STEP_W-1:0]         step_data,
    input  logic [N*N-1:0]            sensor_bits,
    input  logic [N*N-1:0]            pe_out,
    output logic                      exec_o,
    output logic [(1<<STEP_W)-1:0]    sel_a,
    output logic [(1<<STEP_W)-1:0]    sel_b,
    output logic [(1<<STEP_W)-1:0]    op_line,
    output logic [(1<<STEP_W)-1:0]    sel_w,
    output logic [N*N-1:0]            nbr_up,
    output logic [N*N-1:0]            nbr_down,
    output logic [N*N-1:0]            nbr_left,
    output logic [N*N-1:0]            nbr_right,
    output logic [N*N-1:0]            pe_sensor
);

    localparam int SEL_W = 1 << STEP_W;

    logic                          exec_w;
    logic [STEPS-1:0][STEP_W-1:0]  fields;
    logic [STEPS-1:0][SEL_W-1:0]   decoded;
    logic [STEPS-1:0][SEL_W-1:0]   driven;

    bc_seq #(.STEP_W(STEP_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .step_valid (step_valid),
        .step_data  (step_data),
        .exec_o     (exec_w),
        .fields_o   (fields)
    );

    for (genvar g = 0; g < STEPS; g++) begin : g_dec
        onehot_dec #(.IN_W(STEP_W)) u_dec (
            .code  (fields[g]),
            .lines (decoded[g])
        );
    end

    bc_gate #(.LANES(STEPS), .W(SEL_W)) u_gate (
        .en   (exec_w),
        .din  (decoded),
        .dout (driven)
    );

    assign exec_o  = exec_w;
    assign sel_a   = driven[FLD_A];
    assign sel_b   = driven[FLD_B];
    assign op_line = driven[FLD_OP];
    assign sel_w   = driven[FLD_W];

    mesh_route #(.N(N)) u_mesh (
        .pe_out      (pe_out),
        .sensor_bits (sensor_bits),
        .nbr_up      (nbr_up),
        .nbr_down    (nbr_down),
        .nbr_left    (nbr_left),
        .nbr_right   (nbr_right),
        .pe_sensor   (pe_sensor)
    );

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |-> ($countones(sel_a) == 1 && $countones(sel_b) == 1 &&
                    $countones(op_line) == 1 && $countones(sel_w) == 1)); // R4

    AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_o |-> ($countones({sel_a, sel_b, op_line, sel_w}) == 0)); // R4

endmodule

// File: tb/sim_simd_bcast_array.sv
module sim_simd_bcast_array;

    localparam int N      = 8;
    localparam int STEP_W = 5;
    localparam int CELLS  = N * N;
    localparam int SEL_W  = 1 << STEP_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic step_valid = 1'b0;
    logic [STEP_W-1:0] step_data = '0;
    logic [CELLS-1:0] sensor_bits = '0;
    logic [CELLS-1:0] pe_out = '0;
    logic exec_o;
    logic [SEL_W-1:0] sel_a, sel_b, op_line, sel_w;
    logic [CELLS-1:0] nbr_up, nbr_down, nbr_left, nbr_right, pe_sensor;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    simd_bcast_array #(.N(N), .STEP_W(STEP_W)) u0 (
        .clk, .rst_n, .start, .step_valid, .step_data, .sensor_bits, .pe_out,
        .exec_o, .sel_a, .sel_b, .op_line, .sel_w,
        .nbr_up, .nbr_down, .nbr_left, .nbr_right, .pe_sensor
    );

    // {a, b, op, w, gap}
    localparam logic [21:0] TBL [6] = '{
        {5'd0,  5'd31, 5'd7,  5'd31, 2'd0},
        {5'd31, 5'd0,  5'd0,  5'd0,  2'd1},
        {5'd5,  5'd10, 5'd20, 5'd15, 2'd2},
        {5'd1,  5'd2,  5'd3,  5'd4,  2'd3},
        {5'd16, 5'd8,  5'd4,  5'd2,  2'd0},
        {5'd30, 5'd29, 5'd17, 5'd9,  2'd1}
    };

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_step(input logic [STEP_W-1:0] d, input int gap);
        for (int i = 0; i < gap; i++) @(negedge clk);
        @(negedge clk);
        step_valid = 1'b1;
        step_data  = d;
        @(negedge clk);
        step_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_instr(input logic [STEP_W-1:0] a, b, op, w, input int gap);
        send_step(a, gap);
        send_step(b, gap);
        send_step(op, gap);
        send_step(w, gap);
    endtask

    // called at the negedge right after the fourth transfer was accepted
    task automatic check_exec(input logic [STEP_W-1:0] a, b, op, w, input string req);
        logic [SEL_W-1:0] one = 1;
        chk(exec_o === 1'b1, {req, " exec"}, 128'(exec_o), 128'd1);
        chk(sel_a === (one << a) && sel_b === (one << b) &&
            op_line === (one << op) && sel_w === (one << w), {req, " selects"},
            {sel_a, sel_b, op_line, sel_w},
            {one << a, one << b, one << op, one << w});
    endtask

    task automatic check_quiet(input string req);
        chk(exec_o === 1'b0 && {sel_a, sel_b, op_line, sel_w} === '0, req,
            {exec_o, sel_a, sel_b, op_line}, 128'd0);
    endtask

    function automatic logic [CELLS-1:0] shift_mesh(input logic [CELLS-1:0] src,
                                                   input int dr, input int dc);
        logic [CELLS-1:0] res = '0;
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                int rr = r + dr;
                int cc = c + dc;
                if (rr >= 0 && rr < N && cc >= 0 && cc < N)
                    res[r*N + c] = src[rr*N + cc];
            end
        end
        return res;
    endfunction

    task automatic check_mesh(input logic [CELLS-1:0] pat, input logic [CELLS-1:0] sen);
        @(negedge clk);
        pe_out = pat;
        sensor_bits = sen;
        #1;
        chk(nbr_up    === shift_mesh(pat, -1, 0), "R10 R11 up",    nbr_up,    shift_mesh(pat, -1, 0));
        chk(nbr_down  === shift_mesh(pat,  1, 0), "R10 R11 down",  nbr_down,  shift_mesh(pat,  1, 0));
        chk(nbr_left  === shift_mesh(pat, 0, -1), "R10 R11 left",  nbr_left,  shift_mesh(pat, 0, -1));
        chk(nbr_right === shift_mesh(pat, 0,  1), "R10 R11 right", nbr_right, shift_mesh(pat, 0,  1));
        chk(pe_sensor === sen, "R12 sensor", pe_sensor, sen);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1 reset state");

        // R6: transfers before any start are ignored
        send_instr(5'd3, 5'd3, 5'd3, 5'd3, 0);
        check_quiet("R6 no exec without start");
        @(negedge clk);
        check_quiet("R6 still idle");

        // table walk: one start, then back-to-back instructions (R2 R3 R7 R8)
        pulse_start();
        for (int i = 0; i < 6; i++) begin
            logic [4:0] a, b, op, w;
            int gap;
            {a, b, op, w} = TBL[i][21:2];
            gap = int'(TBL[i][1:0]);
            send_instr(a, b, op, w, gap);
            check_exec(a, b, op, w, "R2 R3 R7 table");
            @(negedge clk);
            check_quiet("R3 R4 exec single cycle");
        end

        // R5: restart discards a partial instruction
        send_step(5'd1, 0);
        send_step(5'd2, 0);
        pulse_start();
        send_instr(5'd11, 5'd12, 5'd13, 5'd14, 0);
        check_exec(5'd11, 5'd12, 5'd13, 5'd14, "R5 partial discarded");
        @(negedge clk);

        // R5: transfer coinciding with start is not taken
        @(negedge clk);
        start = 1'b1;
        step_valid = 1'b1;
        step_data = 5'd27;
        @(negedge clk);
        start = 1'b0;
        step_valid = 1'b0;
        send_instr(5'd6, 5'd7, 5'd8, 5'd9, 0);
        check_exec(5'd6, 5'd7, 5'd8, 5'd9, "R5 same-cycle step dropped");

        // R8: transfer offered during EXEC is ignored
        step_valid = 1'b1;
        step_data = 5'd25;
        @(negedge clk);
        step_valid = 1'b0;
        check_quiet("R8 exec ended");
        send_instr(5'd19, 5'd18, 5'd17, 5'd16, 0);
        check_exec(5'd19, 5'd18, 5'd17, 5'd16, "R8 exec-cycle step ignored");

        // R9: start during EXEC keeps the strobe, next instruction fine
        start = 1'b1;
        #1;
        chk(exec_o === 1'b1, "R9 exec kept with start", 128'(exec_o), 128'd1);
        @(negedge clk);
        start = 1'b0;
        check_quiet("R9 after exec");
        send_instr(5'd21, 5'd22, 5'd23, 5'd24, 1);
        check_exec(5'd21, 5'd22, 5'd23, 5'd24, "R9 following instruction");
        @(negedge clk);

        // mesh routing
        check_mesh(64'd1 << 0, 64'hA5A5_0F0F_1234_8001);
        check_mesh(64'd1 << (CELLS - 1), 64'h0);
        check_mesh(64'd1 << 9, 64'hFFFF_FFFF_FFFF_FFFF);
        check_mesh(64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_AAAA_5555_AAAA);
        check_mesh(64'hAA55_AA55_AA55_AA55, 64'h0123_4567_89AB_CDEF);
        check_mesh(64'h8142_2418_1824_4281, 64'hDEAD_BEEF_0BAD_F00D);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule